// File: doc/BRIEF.md
# Power-Managed Mode Sequencer

This block decides, cycle by cycle, whether the processor core and the peripherals of a small controller receive clocks. Software issues a sleep strobe; a sticky idle-enable bit then chooses between an idle state, where only the core clock stops, and a sleep state, where both clocks stop and the selected oscillator is told to shut down. A pending enabled interrupt or a watchdog time-out wakes the block. An asynchronous reset also returns it to the run state.

Every wake passes through a fixed core-ready delay, of a parameterized number of cycles, before the core clock returns. A wake from sleep first waits for the selected oscillator to report ready. The exception is when a fast start-up option lets the core run from the internal oscillator at once. When execution resumes after an interrupt wake with the global interrupt enable set, a one-cycle pulse tells the core to branch to the interrupt vector. The clock multiplexer and the instruction decoder sit outside this block.

Top module: `pm_sequencer`

## Requirements
- R1: Asynchronous reset (rst_n low) puts the block in the run state. mode is 0, cpuClkEn and periClkEn are 1, and oscStop, statusClr, runOnInternal and vectorBranch are 0. The mode codes are run=0, idle=1, sleep=2, oscillator wait=3, core-ready delay=4.
- R2: In run, a sleepStrobe sampled with idleEnable=1 moves the block to idle (mode 1) on the next cycle. In idle cpuClkEn is 0 and periClkEn is 1. R4 describes the one exception.
- R3: In run, a sleepStrobe sampled with idleEnable=0 moves the block to sleep (mode 2). In sleep both clock enables are 0 and oscStop is 1. statusClr is 1 during the first sleep cycle only.
- R4: A sleepStrobe with idleEnable=1, srcSel=2'b01 (secondary source) and secOscEnable=0 is ignored. The block stays in run with both clocks enabled.
- R5: In idle or sleep, only wakeIrq or wakeWdt causes an exit. sleepStrobe, srcReady and the select inputs have no effect there.
- R6: A wake from idle enters the core-ready delay (mode 4) for exactly DELAY cycles, with cpuClkEn=0 and periClkEn=1. The block then returns to run with cpuClkEn=1.
- R7: A wake from sleep with fastStart=0 enters the oscillator wait (mode 3), where both clocks are off. The block stays there until srcReady is sampled high, then passes through the DELAY-cycle core-ready delay to run.
- R8: A wake from sleep with fastStart=1 goes straight to the core-ready delay. runOnInternal is 1 from the first delay cycle until the cycle after srcReady is sampled high.
- R9: Wake events that arrive during the oscillator wait or the core-ready delay are absorbed. They neither restart nor lengthen the delay.
- R10: vectorBranch pulses for one cycle, in the first run cycle after a wake, only if wakeIrq and globalIntEnable were both 1 at the wake edge. A wake by watchdog alone, or with globalIntEnable=0, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleepStrobe | input | 1 | Sleep instruction executed |
| idleEnable | input | 1 | Sticky bit: 1 selects idle, 0 selects sleep |
| srcSel | input | 2 | Selected clock source (01 = secondary) |
| secOscEnable | input | 1 | Secondary oscillator enabled |
| wakeIrq | input | 1 | Enabled interrupt pending |
| wakeWdt | input | 1 | Watchdog time-out |
| globalIntEnable | input | 1 | Global interrupt enable |
| srcReady | input | 1 | Selected oscillator is ready |
| fastStart | input | 1 | Two-speed start-up or fail-safe monitor enabled |
| cpuClkEn | output | 1 | Core clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscStop | output | 1 | Request to stop the selected oscillator |
| statusClr | output | 1 | Pulse that clears the clock-status flags on sleep entry |
| runOnInternal | output | 1 | Core is running from the internal oscillator after a fast wake |
| vectorBranch | output | 1 | Branch to the interrupt vector on resume |
| mode | output | 3 | Current state code |

## Verification
The assertions check on every cycle that the core clock runs only in run mode, and that idle, sleep and oscillator wait hold without the proper trigger. They also check that each core-ready delay lasts exactly DELAY cycles and that a vector pulse follows only an interrupt wake with the global enable set. What the bench's scenarios alone can show is the full round trip through each wake path: the wait on srcReady, the clearing of runOnInternal, and absorbed wakes inside the delay, compared against an independent cycle model.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;
  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_IDLE    = 3'd1,
    PM_SLEEP   = 3'd2,
    PM_OSCWAIT = 3'd3,
    PM_READY   = 3'd4
  } pmState_t;

  typedef struct packed {
    logic loadDelay;    // start the core-ready countdown
    logic captureWake;  // record wake cause for vector decision
    logic fastWake;     // sleep exit through internal oscillator
    logic enterSleep;   // sleep entry, clears status flags
    logic resume;       // last delay cycle, execution resumes next
  } pmStrobe_t;
endpackage

// File: rtl/pm_seq_ctrl.sv
module pm_seq_ctrl
  import pm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepStrobe,
  input  logic       idleEnable,
  input  logic [1:0] srcSel,
  input  logic       secOscEnable,
  input  logic       wakeAny,
  input  logic       srcReady,
  input  logic       fastStart,
  input  logic       delayDone,
  output pmStrobe_t  strb,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       oscStop,
  output logic [2:0] mode
);
  pmState_t state, nextState;
  logic secIdleBlocked;

  assign secIdleBlocked = (srcSel == 2'b01) && !secOscEnable;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      PM_RUN: begin
        if (sleepStrobe) begin
          if (idleEnable) begin
            if (!secIdleBlocked) nextState = PM_IDLE;
          end else begin
            nextState       = PM_SLEEP;
            strb.enterSleep = 1'b1;
          end
        end
      end
      PM_IDLE: begin
        if (wakeAny) begin
          nextState        = PM_READY;
          strb.loadDelay   = 1'b1;
          strb.captureWake = 1'b1;
        end
      end
      PM_SLEEP: begin
        if (wakeAny) begin
          strb.captureWake = 1'b1;
          if (fastStart) begin
            nextState      = PM_READY;
            strb.loadDelay = 1'b1;
            strb.fastWake  = 1'b1;
          end else begin
            nextState = PM_OSCWAIT;
          end
        end
      end
      PM_OSCWAIT: begin
        if (srcReady) begin
          nextState      = PM_READY;
          strb.loadDelay = 1'b1;
        end
      end
      PM_READY: begin
        if (delayDone) begin
          nextState   = PM_RUN;
          strb.resume = 1'b1;
        end
      end
      default: nextState = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PM_RUN;
    else        state <= nextState;
  end

  assign cpuClkEn  = (state == PM_RUN);
  assign periClkEn = (state == PM_RUN) || (state == PM_IDLE) || (state == PM_READY);
  assign oscStop   = (state == PM_SLEEP);
  assign mode      = state;
endmodule

// File: rtl/pm_seq_dp.sv
module pm_seq_dp
  import pm_seq_pkg::*;
#(
  parameter int DELAY = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pmStrobe_t strb,
  input  logic      wakeIrq,
  input  logic      globalIntEnable,
  input  logic      srcReady,
  output logic      delayDone,
  output logic      statusClr,
  output logic      runOnInternal,
  output logic      vectorBranch
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  localparam logic [CW-1:0] LOADVAL = CW'(DELAY - 1);

  logic [CW-1:0] cnt;
  logic branchPend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (strb.loadDelay) cnt <= LOADVAL;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign delayDone = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      branchPend    <= 1'b0;
      vectorBranch  <= 1'b0;
      statusClr     <= 1'b0;
      runOnInternal <= 1'b0;
    end else begin
      if (strb.captureWake) branchPend <= wakeIrq && globalIntEnable;
      vectorBranch <= strb.resume && branchPend;
      statusClr    <= strb.enterSleep;
      if (strb.fastWake)  runOnInternal <= 1'b1;
      else if (srcReady)  runOnInternal <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
  import pm_seq_pkg::*;
#(
  parameter int DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepStrobe,
  input  logic       idleEnable,
  input  logic [1:0] srcSel,
  input  logic       secOscEnable,
  input  logic       wakeIrq,
  input  logic       wakeWdt,
  input  logic       globalIntEnable,
  input  logic       srcReady,
  input  logic       fastStart,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic       oscStop,
  output logic       statusClr,
  output logic       runOnInternal,
  output logic       vectorBranch,
  output logic [2:0] mode
);
  pmStrobe_t strb;
  logic delayDone;
  logic wakeAny;

  assign wakeAny = wakeIrq || wakeWdt;

  pm_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleepStrobe(sleepStrobe), .idleEnable(idleEnable),
    .srcSel(srcSel), .secOscEnable(secOscEnable), .wakeAny(wakeAny),
    .srcReady(srcReady), .fastStart(fastStart), .delayDone(delayDone),
    .strb(strb), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
    .oscStop(oscStop), .mode(mode)
  );

  pm_seq_dp #(.DELAY(DELAY)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wakeIrq(wakeIrq),
    .globalIntEnable(globalIntEnable), .srcReady(srcReady),
    .delayDone(delayDone), .statusClr(statusClr),
    .runOnInternal(runOnInternal), .vectorBranch(vectorBranch)
  );
endmodule

// File: rtl/pm_sequencer_chk.sv
module pm_sequencer_chk
  import pm_seq_pkg::*;
#(
  parameter int DELAY = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sleepStrobe,
  input logic       idleEnable,
  input logic [1:0] srcSel,
  input logic       secOscEnable,
  input logic       wakeIrq,
  input logic       wakeWdt,
  input logic       globalIntEnable,
  input logic       srcReady,
  input logic       fastStart,
  input logic       cpuClkEn,
  input logic       periClkEn,
  input logic       oscStop,
  input logic       statusClr,
  input logic       runOnInternal,
  input logic       vectorBranch,
  input logic [2:0] mode
);
  int unsigned readyLen;
  logic wakeWasIrq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyLen   <= 0;
      wakeWasIrq <= 1'b0;
    end else begin
      readyLen <= (mode == PM_READY) ? readyLen + 1 : 0;
      if ((mode == PM_IDLE || mode == PM_SLEEP) && (wakeIrq || wakeWdt))
        wakeWasIrq <= wakeIrq && globalIntEnable;
    end
  end

  p_cpu_only_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpuClkEn |-> (mode == PM_RUN) && periClkEn);

  p_idle_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) && sleepStrobe && idleEnable && !(srcSel == 2'b01 && !secOscEnable)
    |=> (mode == PM_IDLE) && !cpuClkEn && periClkEn);

  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) && sleepStrobe && !idleEnable |=> (mode == PM_SLEEP) && statusClr && oscStop);

  p_sec_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) && sleepStrobe && idleEnable && srcSel == 2'b01 && !secOscEnable
    |=> (mode == PM_RUN) && cpuClkEn);

  p_low_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_IDLE || mode == PM_SLEEP) && !wakeIrq && !wakeWdt |=> $stable(mode));

  p_osc_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_OSCWAIT) && !srcReady |=> (mode == PM_OSCWAIT));

  p_fast_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP) && (wakeIrq || wakeWdt) && fastStart |=> (mode == PM_READY) && runOnInternal);

  p_delay_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PM_READY) && (readyLen != 0) |-> readyLen == DELAY);

  p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vectorBranch |-> wakeWasIrq && (mode == PM_RUN) && ($past(mode) == PM_READY));
endmodule

bind pm_sequencer pm_sequencer_chk #(.DELAY(DELAY)) u_chk (.*);

// File: tb/test_pm_sequencer.sv
`timescale 1ns/1ps
module test_pm_sequencer;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepStrobe = 0, idleEnable = 0, secOscEnable = 0;
  logic wakeIrq = 0, wakeWdt = 0, globalIntEnable = 0, srcReady = 0, fastStart = 0;
  logic [1:0] srcSel = 2'b00;
  logic cpuClkEn, periClkEn, oscStop, statusClr, runOnInternal, vectorBranch;
  logic [2:0] mode;

  int nVec = 0, nFail = 0;
  string curTag = "R1";

  // reference model state
  int mState = 0, mCnt = 0;
  bit mBr = 0, mVec = 0, mClr = 0, mFast = 0;

  always #5 clk = ~clk;

  pm_sequencer #(.DELAY(DLY)) i_pm_sequencer (
    .clk(clk), .rst_n(rst_n), .sleepStrobe(sleepStrobe), .idleEnable(idleEnable),
    .srcSel(srcSel), .secOscEnable(secOscEnable), .wakeIrq(wakeIrq), .wakeWdt(wakeWdt),
    .globalIntEnable(globalIntEnable), .srcReady(srcReady), .fastStart(fastStart),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .oscStop(oscStop), .statusClr(statusClr),
    .runOnInternal(runOnInternal), .vectorBranch(vectorBranch), .mode(mode)
  );

  function automatic bit expCpu(int s);  return s == 0; endfunction
  function automatic bit expPeri(int s); return s == 0 || s == 1 || s == 4; endfunction
  function automatic bit expOsc(int s);  return s == 2; endfunction

  task automatic modelStep();
    bit wk, setFast;
    wk = wakeIrq || wakeWdt;
    setFast = 0;
    mVec = 0;
    mClr = 0;
    case (mState)
      0: if (sleepStrobe) begin
           if (!idleEnable) begin mState = 2; mClr = 1; end
           else if (!(srcSel == 2'b01 && !secOscEnable)) mState = 1;
         end
      1: if (wk) begin mState = 4; mCnt = DLY; mBr = wakeIrq && globalIntEnable; end
      2: if (wk) begin
           mBr = wakeIrq && globalIntEnable;
           if (fastStart) begin mState = 4; mCnt = DLY; setFast = 1; end
           else mState = 3;
         end
      3: if (srcReady) begin mState = 4; mCnt = DLY; end
      default: begin
           mCnt = mCnt - 1;
           if (mCnt == 0) begin mState = 0; mVec = mBr; end
         end
    endcase
    if (setFast) mFast = 1;
    else if (srcReady) mFast = 0;
  endtask

  task automatic compare();
    nVec++;
    if (mode !== 3'(mState) || cpuClkEn !== expCpu(mState) || periClkEn !== expPeri(mState) ||
        oscStop !== expOsc(mState) || statusClr !== mClr || runOnInternal !== mFast ||
        vectorBranch !== mVec) begin
      nFail++;
      $display("FAIL %s t=%0t act mode=%0d cpu=%b peri=%b osc=%b clr=%b int=%b vec=%b exp mode=%0d cpu=%b peri=%b osc=%b clr=%b int=%b vec=%b",
               curTag, $time, mode, cpuClkEn, periClkEn, oscStop, statusClr, runOnInternal, vectorBranch,
               mState, expCpu(mState), expPeri(mState), expOsc(mState), mClr, mFast, mVec);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    #1;
    compare();
  endtask

  task automatic quiet();
    sleepStrobe = 0; wakeIrq = 0; wakeWdt = 0; srcReady = 0;
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    int seed;
    #23;
    curTag = "R1"; // reset state
    compare();
    rst_n = 1'b1;
    runCycles(2);

    // R2: idle entry, then R6 wake from idle with interrupt, gie=0
    curTag = "R2";
    idleEnable = 1; srcSel = 2'b00; sleepStrobe = 1; cycle(); quiet();
    runCycles(2);
    curTag = "R6";
    wakeIrq = 1; globalIntEnable = 0; cycle(); quiet();
    runCycles(DLY + 2);

    // R4: secondary idle refused when secondary oscillator disabled
    curTag = "R4";
    srcSel = 2'b01; secOscEnable = 0; sleepStrobe = 1; cycle(); quiet();
    runCycles(2);

    // R3: sleep entry; R5: strobes and ready ignored while asleep
    curTag = "R3";
    idleEnable = 0; srcSel = 2'b00; sleepStrobe = 1; cycle(); quiet();
    cycle();
    curTag = "R5";
    sleepStrobe = 1; srcReady = 1; idleEnable = 1; runCycles(3); quiet();
    idleEnable = 0;

    // R7: watchdog wake, oscillator wait until ready; R9 absorbed wakes
    curTag = "R7";
    fastStart = 0; wakeWdt = 1; cycle(); quiet();
    runCycles(3);
    curTag = "R9";
    wakeIrq = 1; cycle(); wakeIrq = 0;
    srcReady = 1; cycle(); srcReady = 0;
    wakeWdt = 1; wakeIrq = 1; runCycles(2); quiet();
    runCycles(DLY);

    // R8: fast start wake runs from internal until ready
    curTag = "R8";
    sleepStrobe = 1; cycle(); quiet();
    fastStart = 1; wakeWdt = 1; cycle(); quiet();
    runCycles(DLY + 2);
    srcReady = 1; cycle(); srcReady = 0;
    runCycles(2);

    // R10: interrupt wake with gie=1 gives vector pulse
    curTag = "R10";
    idleEnable = 1; srcSel = 2'b10; sleepStrobe = 1; cycle(); quiet();
    wakeIrq = 1; globalIntEnable = 1; cycle(); quiet();
    runCycles(DLY + 2);

    // constrained random mix (R5 and all others via model)
    curTag = "R5";
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4000; i++) begin
      sleepStrobe     = ($urandom % 4) == 0;
      idleEnable      = $urandom % 2;
      srcSel          = 2'($urandom % 4);
      secOscEnable    = $urandom % 2;
      wakeIrq         = ($urandom % 8) == 0;
      wakeWdt         = ($urandom % 10) == 0;
      globalIntEnable = $urandom % 2;
      srcReady        = ($urandom % 3) == 0;
      fastStart       = $urandom % 2;
      cycle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog expired: act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule